// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, how each of the five pipeline registers of an in-order processor (fetch, decode, execute, memory, writeback) should update at the next rising clock edge. It looks at the instruction codes held in the decode, execute and memory stages, at the two source register identifiers being read in decode, at the memory destination of the execute-stage instruction, and at the branch condition computed in execute. From these it flags three events: a load followed by a use of the loaded register, a conditional jump that was wrongly predicted taken, and a return instruction somewhere between decode and memory. It then turns these events into a hold (stall) or a no-op insertion (bubble) for each register.

The same block contains the five stage registers. Each has three modes: normal load, hold, and load of a no-op word. Their payload width and the no-op word are parameters. The control outputs are combinational and are also brought out so that the surrounding datapath can see them. When events overlap, the block settles the conflict explicitly: a load/use hazard wins over a pending return, and a mispredicted jump wins when a return sits at its target.

Top module: `hz_ctrl_top`

## Requirements
- R1: If the execute code is a memory read (load 0x5 or pop 0xB) and its memory destination equals either decode source, the fetch and decode registers hold, the execute register takes a bubble, and memory and writeback load normally. Mode vectors use bit 0 for fetch, 1 for decode, 2 for execute, 3 for memory and 4 for writeback.
- R2: Register identifier 0xF means no register and never produces a load/use match, even when the destination and a source are both 0xF.
- R3: If the execute code is a jump (0x7) and the condition input is 0, decode and execute take a bubble. A jump whose condition is 1 causes no stall and no bubble.
- R4: While a return (0x9) is in the decode, execute or memory stage, fetch holds and decode takes a bubble.
- R5: If a load/use hazard and a pending return occur together, fetch and decode hold, execute takes a bubble, and decode gets no bubble.
- R6: If a mispredicted jump is in execute while a return is in decode, decode and execute take a bubble and fetch holds.
- R7: No stage ever has stall and bubble asserted together, and the memory and writeback registers never hold or bubble.
- R8: A stage register with neither stall nor bubble takes its input at the next rising edge.
- R9: A stage register with stall asserted keeps its value across the edge.
- R10: A stage register with bubble asserted loads the no-op word (default 0x1F: no-op code 0x1 in the upper nibble, no-register 0xF in the lower).
- R11: While reset is low, every stage register holds the no-op word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the stage registers |
| dec_src_a | input | 4 | First source register read in decode |
| dec_src_b | input | 4 | Second source register read in decode |
| dec_code | input | 4 | Instruction code in decode |
| ex_code | input | 4 | Instruction code in execute |
| ex_dst_m | input | 4 | Memory destination register of the execute instruction |
| ex_cond | input | 1 | Branch condition computed in execute |
| mem_code | input | 4 | Instruction code in memory |
| stage_d | input | 5*DATA_W | Next values of the five stage registers, fetch in the lowest slice |
| stage_q | output | 5*DATA_W | Current values of the five stage registers |
| stall_o | output | 5 | Hold request per stage, bit 0 fetch to bit 4 writeback |
| bubble_o | output | 5 | No-op load request per stage, same bit order |

## Verification
The hardest case to reach from the ports is the overlap of a load/use hazard with a return still in flight, since it needs a memory-read code in execute, a destination equal to a live decode source, and a return code in decode or memory all in one cycle. Uniform random codes would almost never line these up, so the stimulus draws codes from a pool weighted toward load, pop, jump and return and draws register identifiers from a small set that includes 0xF. Directed cycles also place each overlap on purpose, and every cycle checks both the mode vectors and the resulting register contents one edge later.

// File: rtl/hz_pkg.sv
package hz_pkg;

  localparam int CODE_W  = 4;
  localparam int RID_W   = 4;
  localparam int NUM_STG = 5;

  localparam int STG_F = 0;
  localparam int STG_D = 1;
  localparam int STG_E = 2;
  localparam int STG_M = 3;
  localparam int STG_W = 4;

  localparam logic [CODE_W-1:0] OP_NOP  = 4'h1;
  localparam logic [CODE_W-1:0] OP_LOAD = 4'h5;
  localparam logic [CODE_W-1:0] OP_JUMP = 4'h7;
  localparam logic [CODE_W-1:0] OP_RET  = 4'h9;
  localparam logic [CODE_W-1:0] OP_POP  = 4'hB;

  localparam logic [RID_W-1:0] RID_NONE = '1;

  typedef struct packed {
    logic load_use;
    logic mispred;
    logic ret_pend;
  } hz_evt_t;

  typedef logic [NUM_STG-1:0] stg_vec_t;

  function automatic logic reads_memory(input logic [CODE_W-1:0] code);
    return (code == OP_LOAD) || (code == OP_POP);
  endfunction

  function automatic logic rid_hit(input logic [RID_W-1:0] dst,
                                   input logic [RID_W-1:0] src);
    return (dst != RID_NONE) && (dst == src);
  endfunction

  function automatic logic is_ret(input logic [CODE_W-1:0] code);
    return code == OP_RET;
  endfunction

endpackage

// File: rtl/hz_detect.sv
module hz_detect
  import hz_pkg::*;
(
  input  logic [RID_W-1:0]  src_a,
  input  logic [RID_W-1:0]  src_b,
  input  logic [CODE_W-1:0] d_code,
  input  logic [CODE_W-1:0] e_code,
  input  logic [RID_W-1:0]  e_dst_m,
  input  logic              e_cond,
  input  logic [CODE_W-1:0] m_code,
  output hz_evt_t           evt_o
);

  logic mem_rd_in_ex;
  logic dst_hits_src;
  logic jump_in_ex;
  logic ret_seen;

  assign mem_rd_in_ex = reads_memory(e_code);
  assign dst_hits_src = rid_hit(e_dst_m, src_a) || rid_hit(e_dst_m, src_b);
  assign jump_in_ex   = (e_code == OP_JUMP);
  assign ret_seen     = is_ret(d_code) || is_ret(e_code) || is_ret(m_code);

  always_comb begin
    evt_o          = '0;
    evt_o.load_use = mem_rd_in_ex && dst_hits_src;
    evt_o.mispred  = jump_in_ex && !e_cond;
    evt_o.ret_pend = ret_seen;
  end

endmodule

// File: rtl/hz_action.sv
module hz_action
  import hz_pkg::*;
(
  input  hz_evt_t  evt_i,
  output stg_vec_t stall_o,
  output stg_vec_t bubble_o
);

  logic ret_bubbles_d;

  assign ret_bubbles_d = evt_i.ret_pend && !evt_i.load_use;

  always_comb begin
    stall_o  = '0;
    bubble_o = '0;
    stall_o[STG_F]  = evt_i.load_use || evt_i.ret_pend;
    stall_o[STG_D]  = evt_i.load_use;
    bubble_o[STG_D] = evt_i.mispred || ret_bubbles_d;
    bubble_o[STG_E] = evt_i.mispred || evt_i.load_use;
  end

endmodule

// File: rtl/pipe_stage_reg.sv
module pipe_stage_reg #(
  parameter int               WIDTH   = 8,
  parameter logic [WIDTH-1:0] NOP_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             bubble,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= NOP_VAL;
    else if (stall)  q <= q;
    else if (bubble) q <= NOP_VAL;
    else             q <= d;
  end

endmodule

// File: rtl/hz_ctrl_top.sv
module hz_ctrl_top
  import hz_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] NOP_WORD = 8'h1F
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [3:0]                dec_src_a,
  input  logic [3:0]                dec_src_b,
  input  logic [3:0]                dec_code,
  input  logic [3:0]                ex_code,
  input  logic [3:0]                ex_dst_m,
  input  logic                      ex_cond,
  input  logic [3:0]                mem_code,
  input  logic [5*DATA_W-1:0]       stage_d,
  output logic [5*DATA_W-1:0]       stage_q,
  output logic [4:0]                stall_o,
  output logic [4:0]                bubble_o
);

  localparam int BUS_W = NUM_STG * DATA_W;

  hz_evt_t  evt;
  stg_vec_t stall_v;
  stg_vec_t bubble_v;

  hz_detect u_detect (
    .src_a   (dec_src_a),
    .src_b   (dec_src_b),
    .d_code  (dec_code),
    .e_code  (ex_code),
    .e_dst_m (ex_dst_m),
    .e_cond  (ex_cond),
    .m_code  (mem_code),
    .evt_o   (evt)
  );

  hz_action u_action (
    .evt_i    (evt),
    .stall_o  (stall_v),
    .bubble_o (bubble_v)
  );

  assign stall_o  = stall_v;
  assign bubble_o = bubble_v;

  logic [BUS_W-1:0] q_bus;

  for (genvar g = 0; g < NUM_STG; g++) begin : g_stage
    pipe_stage_reg #(
      .WIDTH   (DATA_W),
      .NOP_VAL (NOP_WORD)
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .stall  (stall_v[g]),
      .bubble (bubble_v[g]),
      .d      (stage_d[g*DATA_W +: DATA_W]),
      .q      (q_bus[g*DATA_W +: DATA_W])
    );
  end

  assign stage_q = q_bus;

endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk
  import hz_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] NOP_WORD = 8'h1F
) (
  input logic                clk,
  input logic                rst_n,
  input logic [3:0]          dec_src_a,
  input logic [3:0]          dec_src_b,
  input logic [3:0]          dec_code,
  input logic [3:0]          ex_code,
  input logic [3:0]          ex_dst_m,
  input logic                ex_cond,
  input logic [3:0]          mem_code,
  input logic [5*DATA_W-1:0] stage_d,
  input logic [5*DATA_W-1:0] stage_q,
  input logic [4:0]          stall_o,
  input logic [4:0]          bubble_o
);

  logic lu_seen;
  logic ret_seen;
  assign lu_seen = (ex_code == 4'h5 || ex_code == 4'hB) && ex_dst_m != 4'hF &&
                   (ex_dst_m == dec_src_a || ex_dst_m == dec_src_b);
  assign ret_seen = dec_code == 4'h9 || ex_code == 4'h9 || mem_code == 4'h9;

  p_load_use_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lu_seen |-> (stall_o[1:0] == 2'b11 && bubble_o[2] && stall_o[4:2] == 3'b000));

  p_no_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst_m == 4'hF) |-> !stall_o[1]);

  p_mispred_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_code == 4'h7 && !ex_cond) |-> (bubble_o[1] && bubble_o[2]));

  p_ret_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_seen && !lu_seen) |-> (stall_o[0] && bubble_o[1]));

  p_lu_over_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_seen && lu_seen) |-> (stall_o[1] && !bubble_o[1]));

  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((stall_o & bubble_o) == 5'b0) && stall_o[4:3] == 2'b0 && bubble_o[4:3] == 2'b0);

  for (genvar g = 0; g < 5; g++) begin : g_reg_chk
    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_o[g] && !bubble_o[g]) |=>
        stage_q[g*DATA_W +: DATA_W] == $past(stage_d[g*DATA_W +: DATA_W]));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o[g] |=> $stable(stage_q[g*DATA_W +: DATA_W]));
    p_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bubble_o[g] && !stall_o[g]) |=> stage_q[g*DATA_W +: DATA_W] == NOP_WORD);
  end

endmodule

bind hz_ctrl_top hz_ctrl_chk #(.DATA_W(DATA_W), .NOP_WORD(NOP_WORD)) chk_i (
  .clk(clk), .rst_n(rst_n), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
  .dec_code(dec_code), .ex_code(ex_code), .ex_dst_m(ex_dst_m), .ex_cond(ex_cond),
  .mem_code(mem_code), .stage_d(stage_d), .stage_q(stage_q),
  .stall_o(stall_o), .bubble_o(bubble_o)
);

// File: tb/hz_ctrl_top_tb.sv
`timescale 1ns/1ps
module hz_ctrl_top_tb_top;

  localparam int DW = 8;
  localparam logic [DW-1:0] NOPW = 8'h1F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] src_a = 4'hF, src_b = 4'hF, dcode = 4'h1, ecode = 4'h1, edst = 4'hF, mcode = 4'h1;
  logic econd = 1'b0;
  logic [5*DW-1:0] sd = '0;
  logic [5*DW-1:0] sq;
  logic [4:0] st, bu;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [5*DW-1:0] exp_q;

  always #2.5 clk = ~clk;

  hz_ctrl_top #(.DATA_W(DW), .NOP_WORD(NOPW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dec_src_a(src_a), .dec_src_b(src_b),
    .dec_code(dcode), .ex_code(ecode), .ex_dst_m(edst), .ex_cond(econd),
    .mem_code(mcode), .stage_d(sd), .stage_q(sq), .stall_o(st), .bubble_o(bu)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  // bench view of the rules: returns {bubble, stall}
  function automatic logic [9:0] model();
    logic lu, mis, rt;
    logic [4:0] s, b;
    lu  = (ecode == 4'h5 || ecode == 4'hB) && (edst != 4'hF) &&
          (edst == src_a || edst == src_b);
    mis = (ecode == 4'h7) && (econd == 1'b0);
    rt  = (dcode == 4'h9) || (ecode == 4'h9) || (mcode == 4'h9);
    s = 5'b0; b = 5'b0;
    if (lu) begin s[0] = 1; s[1] = 1; b[2] = 1; end
    if (mis) begin b[1] = 1; b[2] = 1; end
    if (rt) begin
      s[0] = 1;
      if (!lu) b[1] = 1;
    end
    return {b, s};
  endfunction

  function automatic string tag_of();
    logic lu, mis, rt;
    lu  = (ecode == 4'h5 || ecode == 4'hB) && (edst != 4'hF) &&
          (edst == src_a || edst == src_b);
    mis = (ecode == 4'h7) && !econd;
    rt  = (dcode == 4'h9) || (ecode == 4'h9) || (mcode == 4'h9);
    if (lu && rt) return "R5";
    if (mis && rt) return "R6";
    if (lu) return "R1";
    if (mis) return "R3";
    if (rt) return "R4";
    if (edst == 4'hF) return "R2";
    return "R7";
  endfunction

  // called at a negedge with inputs already set
  task automatic step(input string note);
    logic [9:0] m;
    string qtag;
    #1;
    m = model();
    chk({tag_of(), " ctl ", note}, {54'b0, bu, st}, {54'b0, m});
    chk({"R7 excl ", note}, {59'b0, (st & bu) | {st[4:3], 3'b0} | {bu[4:3], 3'b0}}, 64'b0);
    for (int i = 0; i < 5; i++) begin
      if (m[i])          exp_q[i*DW +: DW] = exp_q[i*DW +: DW];
      else if (m[5 + i]) exp_q[i*DW +: DW] = NOPW;
      else               exp_q[i*DW +: DW] = sd[i*DW +: DW];
    end
    if (m[4:0] != 0) qtag = "R9";
    else if (m[9:5] != 0) qtag = "R10";
    else qtag = "R8";
    @(negedge clk);
    chk({qtag, " regs ", note}, {24'b0, sq}, {24'b0, exp_q});
  endtask

  task automatic set_in(input logic [3:0] a, input logic [3:0] b, input logic [3:0] dc,
                        input logic [3:0] ec, input logic [3:0] ed, input logic c,
                        input logic [3:0] mc);
    src_a = a; src_b = b; dcode = dc; ecode = ec; edst = ed; econd = c; mcode = mc;
    for (int i = 0; i < 5; i++) sd[i*DW +: DW] = DW'($urandom);
  endtask

  function automatic logic [3:0] pick_code();
    int r;
    r = $urandom % 8;
    case (r)
      0: return 4'h5;
      1: return 4'hB;
      2: return 4'h7;
      3: return 4'h9;
      default: return 4'($urandom);
    endcase
  endfunction

  function automatic logic [3:0] pick_rid();
    if ($urandom % 5 == 0) return 4'hF;
    return 4'($urandom % 4);
  endfunction

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    sd = '1;
    repeat (3) @(negedge clk);
    chk("R11 reset", {24'b0, sq}, {24'b0, {5{NOPW}}});
    exp_q = {5{NOPW}};
    rst_n = 1'b1;

    set_in(4'h1, 4'h2, 4'h6, 4'h2, 4'h3, 1'b1, 4'h1); step("plain");
    set_in(4'h3, 4'h2, 4'h6, 4'h5, 4'h3, 1'b0, 4'h1); step("load hits src a");
    set_in(4'h0, 4'h4, 4'h6, 4'hB, 4'h4, 1'b0, 4'h1); step("pop hits src b");
    set_in(4'hF, 4'hF, 4'h6, 4'h5, 4'hF, 1'b0, 4'h1); step("none reg R2");
    set_in(4'h1, 4'h2, 4'h6, 4'h7, 4'h3, 1'b0, 4'h1); step("jump not taken R3");
    set_in(4'h1, 4'h2, 4'h6, 4'h7, 4'h3, 1'b1, 4'h1); step("jump taken R3");
    set_in(4'h1, 4'h2, 4'h9, 4'h2, 4'hF, 1'b0, 4'h1); step("ret decode R4");
    set_in(4'h1, 4'h2, 4'h6, 4'h9, 4'hF, 1'b0, 4'h1); step("ret execute R4");
    set_in(4'h1, 4'h2, 4'h6, 4'h2, 4'hF, 1'b0, 4'h9); step("ret memory R4");
    set_in(4'h4, 4'h2, 4'h9, 4'h5, 4'h4, 1'b0, 4'h1); step("load plus ret R5");
    set_in(4'h4, 4'h2, 4'h6, 4'hB, 4'h2, 1'b0, 4'h9); step("pop plus ret mem R5");
    set_in(4'h1, 4'h2, 4'h9, 4'h7, 4'hF, 1'b0, 4'h1); step("mispred ret target R6");
    for (int k = 0; k < 3; k++) begin
      set_in(4'h1, 4'h2, 4'h6, 4'h5, 4'h1, 1'b0, 4'h1); step("repeated stall R9");
    end

    for (int n = 0; n < 3000; n++) begin
      set_in(pick_rid(), pick_rid(), pick_code(), pick_code(), pick_rid(),
             1'($urandom), pick_code());
      step("random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule